// File: doc/BRIEF.md
# Column-Ordered Framebuffer Pixel Scanout

This block reads a video memory in which each byte carries two horizontally adjacent 4-bit pixels. It turns that memory into a continuous pixel stream for a raster display. The memory is column-major. The high address byte picks a two-pixel-wide column and the low address byte picks the display row. The scanner, however, walks the picture in display order: row after row, and left to right inside each row. It therefore issues one memory read every two pixel clocks, with an address built from its column and row counters.

Each 4-bit pixel selects one of sixteen 8-bit colour registers. The selected register is expanded into 8-bit red, green and blue intensities using fixed, non-linear bit weights. The colour registers are written through a simple write port at any time, and a change is seen on the following pixels with no frame-boundary buffering. Only a window of rows is scanned. The number of columns and the first and last visible rows are parameters, and their defaults give a 304-pixel-wide, 240-line picture.

Top module: `column_scanout`

## Requirements
- R1: While reset is asserted, `pix_valid` and `vram_rd` are 0 and every colour register is cleared to 0, so pixels show as black until they are written.
- R2: The read address is `vram_addr[15:8]` = column index (0 to COLS-1) and `vram_addr[7:0]` = row index (ROW_FIRST to ROW_LAST).
- R3: The first read after reset is column 0 of row ROW_FIRST. Columns then advance in increasing order within a row, rows advance in increasing order, and after column COLS-1 of row ROW_LAST the scan wraps to column 0 of row ROW_FIRST.
- R4: `vram_rd` is high on alternate clock cycles, so one byte is read every two clocks.
- R5: The upper nibble of a byte is the pixel at x = 2*column and the lower nibble is the pixel at x = 2*column+1, with y equal to the row.
- R6: `vram_rdata` is sampled on the clock edge after the cycle in which `vram_rd` is high. The left pixel of that byte appears on the outputs two cycles after the read cycle, and the right pixel appears one cycle later. Once it has risen, `pix_valid` stays high on every cycle.
- R7: In a colour register, red is bits [2:0], green is bits [5:3] and blue is bits [7:6]. For red and green, bit weights 33, 71 and 151 from the LSB up are summed. For blue, weights 71 and 151 are summed. For example, 0xFF gives (255,255,222) and 0x94 gives (151,71,151).
- R8: A write with `pal_we` high updates register `pal_idx` on that clock edge. A pixel registered on that same edge still uses the old value, and pixels registered on any later edge use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_we | input | 1 | Colour register write enable |
| pal_idx | input | 4 | Colour register index |
| pal_wdata | input | 8 | Colour register value, blue[7:6] green[5:3] red[2:0] |
| vram_rd | output | 1 | Video memory read strobe |
| vram_addr | output | 16 | Video memory address, column in [15:8], row in [7:0] |
| vram_rdata | input | 8 | Video memory data, valid the cycle after the read |
| pix_valid | output | 1 | Pixel output valid |
| pix_x | output | XW | Pixel column |
| pix_y | output | 8 | Pixel row |
| pix_r | output | 8 | Red intensity |
| pix_g | output | 8 | Green intensity |
| pix_b | output | 8 | Blue intensity |

## Verification
The bench looks at the wrap from the last column of the last row back to the first visible row. A counter that forgot to reload the starting row would go on to an invisible row, and one that missed a column boundary would give a gap or a repeated x. It checks nibble order and the read-to-pixel latency at the ports. A design that swapped nibbles, or that was off by one register stage, would show colours from the wrong address. It writes colour registers while pixels are streaming, so a design that bypassed the new value into the same-edge lookup, or that delayed it, is caught. The weighted expansion is checked against hand-computed intensities for single-bit and mixed register values.

// File: rtl/column_scanout.sv
module column_scanout #(
  parameter int COLS      = 152,
  parameter int ROW_FIRST = 6,
  parameter int ROW_LAST  = 245,
  localparam int XW = $clog2(2 * COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pal_we,
  input  logic [3:0]    pal_idx,
  input  logic [7:0]    pal_wdata,
  output logic          vram_rd,
  output logic [15:0]   vram_addr,
  input  logic [7:0]    vram_rdata,
  output logic          pix_valid,
  output logic [XW-1:0] pix_x,
  output logic [7:0]    pix_y,
  output logic [7:0]    pix_r,
  output logic [7:0]    pix_g,
  output logic [7:0]    pix_b
);

  localparam logic [7:0] COL_END = 8'(COLS - 1);
  localparam logic [7:0] ROW_BEG = 8'(ROW_FIRST);
  localparam logic [7:0] ROW_END = 8'(ROW_LAST);

  logic       active, half;
  logic [7:0] col, row, col_d, row_d;
  logic       dat_q, right_q;
  logic [3:0] lo_nib;
  logic [7:0] pal [16];

  function automatic logic [7:0] weigh3(input logic [2:0] b);
    return (b[0] ? 8'd33 : 8'd0) + (b[1] ? 8'd71 : 8'd0) + (b[2] ? 8'd151 : 8'd0);
  endfunction

  function automatic logic [23:0] expand(input logic [7:0] c);
    return {weigh3(c[2:0]), weigh3(c[5:3]), weigh3({c[7:6], 1'b0})};
  endfunction

  assign vram_rd   = active & ~half;
  assign vram_addr = {col, row};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      half   <= 1'b0;
      col    <= '0;
      row    <= ROW_BEG;
    end else begin
      active <= 1'b1;
      if (active) begin
        half <= ~half;
        if (half) begin
          if (col == COL_END) begin
            col <= '0;
            row <= (row == ROW_END) ? ROW_BEG : 8'(row + 8'd1);
          end else begin
            col <= 8'(col + 8'd1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) pal[i] <= '0;
    end else if (pal_we) begin
      pal[pal_idx] <= pal_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q   <= 1'b0;
      right_q <= 1'b0;
      col_d   <= '0;
      row_d   <= '0;
    end else begin
      dat_q   <= vram_rd;
      right_q <= dat_q;
      if (vram_rd) begin
        col_d <= col;
        row_d <= row;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid           <= 1'b0;
      pix_x               <= '0;
      pix_y               <= '0;
      lo_nib              <= '0;
      {pix_r,pix_g,pix_b} <= '0;
    end else if (dat_q) begin
      pix_valid           <= 1'b1;
      pix_x               <= XW'({col_d, 1'b0});
      pix_y               <= row_d;
      lo_nib              <= vram_rdata[3:0];
      {pix_r,pix_g,pix_b} <= expand(pal[vram_rdata[7:4]]);
    end else if (right_q) begin
      pix_valid           <= 1'b1;
      pix_x               <= pix_x + 1'b1;
      {pix_r,pix_g,pix_b} <= expand(pal[lo_nib]);
    end else begin
      pix_valid <= 1'b0;
    end
  end

endmodule

module column_scanout_chk #(
  parameter int COLS      = 152,
  parameter int ROW_FIRST = 6,
  parameter int ROW_LAST  = 245,
  localparam int XW = $clog2(2 * COLS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vram_rd,
  input logic [15:0]   vram_addr,
  input logic          pix_valid,
  input logic [XW-1:0] pix_x,
  input logic [7:0]    pix_y
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !pix_valid && !vram_rd);

  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |-> (int'(vram_addr[15:8]) < COLS) && (int'(vram_addr[7:0]) >= ROW_FIRST)
                && (int'(vram_addr[7:0]) <= ROW_LAST));

  assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |=> !vram_rd);

  assert_stream_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_valid);

  assert_left_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vram_rd, 2) |-> pix_valid && (pix_x == XW'({$past(vram_addr[15:8], 2), 1'b0}))
                          && (pix_y == $past(vram_addr[7:0], 2)));

  assert_x_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && $past(pix_valid) && (int'($past(pix_x)) != 2 * COLS - 1)
      |-> pix_x == XW'($past(pix_x) + 1'b1) && pix_y == $past(pix_y));

endmodule

bind column_scanout column_scanout_chk #(
  .COLS(COLS), .ROW_FIRST(ROW_FIRST), .ROW_LAST(ROW_LAST)
) chk_i (
  .clk(clk), .rst_n(rst_n), .vram_rd(vram_rd), .vram_addr(vram_addr),
  .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y)
);

// File: tb/column_scanout_tb.sv
module column_scanout_tb_top;
  localparam int COLS = 4;
  localparam int RF   = 6;
  localparam int RL   = 8;
  localparam int XW   = $clog2(2 * COLS);

  localparam logic [31:0] VEC [9] = '{
    {8'hFF, 8'd255, 8'd255, 8'd222},
    {8'h00, 8'd0,   8'd0,   8'd0  },
    {8'h07, 8'd255, 8'd0,   8'd0  },
    {8'h38, 8'd0,   8'd255, 8'd0  },
    {8'hC0, 8'd0,   8'd0,   8'd222},
    {8'h01, 8'd33,  8'd0,   8'd0  },
    {8'h0A, 8'd71,  8'd33,  8'd0  },
    {8'h94, 8'd151, 8'd71,  8'd151},
    {8'h49, 8'd33,  8'd33,  8'd71 }
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pal_we = 1'b0;
  logic [3:0] pal_idx = '0;
  logic [7:0] pal_wdata = '0;
  logic vram_rd;
  logic [15:0] vram_addr;
  logic [7:0] vram_rdata = '0;
  logic pix_valid;
  logic [XW-1:0] pix_x;
  logic [7:0] pix_y, pix_r, pix_g, pix_b;

  int errs = 0, checks = 0;
  always #4 clk = ~clk;

  column_scanout #(.COLS(COLS), .ROW_FIRST(RF), .ROW_LAST(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .pal_idx(pal_idx),
    .pal_wdata(pal_wdata), .vram_rd(vram_rd), .vram_addr(vram_addr),
    .vram_rdata(vram_rdata), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b));

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return 8'(a[15:8] * 8'd29 + a[7:0] * 8'd13 + 8'd5);
  endfunction

  function automatic logic [7:0] w3(input logic [2:0] b);
    return (b[0] ? 8'd33 : 8'd0) + (b[1] ? 8'd71 : 8'd0) + (b[2] ? 8'd151 : 8'd0);
  endfunction

  always @(posedge clk) if (vram_rd) vram_rdata <= mem_byte(vram_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] mpal [16];
  bit pend = 0;
  logic [3:0] pend_i;
  logic [7:0] pend_v;
  bit mon_en = 0, started = 0;
  int ex = 0, ey = RF;
  logic rd1 = 0, rd2 = 0;
  logic [15:0] a1, a2;

  initial for (int i = 0; i < 16; i++) mpal[i] = '0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (rd2) begin
        check(pix_valid && int'(pix_x) == 2 * int'(a2[15:8]) && pix_y == a2[7:0], "R6 latency",
              {pix_valid, 7'd0, 8'(pix_x), pix_y}, {8'h80, 8'(2 * a2[15:8]), a2[7:0]});
      end
      if (pix_valid) begin
        logic [7:0] byt, c;
        logic [3:0] nib;
        started = 1;
        check(int'(pix_x) == ex && int'(pix_y) == ey, "R3 order",
              {8'(pix_x), pix_y}, {8'(ex), 8'(ey)});
        byt = mem_byte({8'(pix_x >> 1), pix_y});
        nib = pix_x[0] ? byt[3:0] : byt[7:4];
        c   = mpal[nib];
        check({pix_r, pix_g, pix_b} == {w3(c[2:0]), w3(c[5:3]), w3({c[7:6], 1'b0})},
              pend ? "R8 write timing" : "R5 R7 colour",
              {pix_r, pix_g, pix_b}, {w3(c[2:0]), w3(c[5:3]), w3({c[7:6], 1'b0})});
        if (ex == 2 * COLS - 1) begin
          ex = 0;
          ey = (ey == RL) ? RF : ey + 1;
        end else ex = ex + 1;
      end else if (started) begin
        check(0, "R6 gap", 0, 1);
      end
      if (vram_rd) check(vram_addr[7:0] >= 8'(RF) && vram_addr[7:0] <= 8'(RL)
                         && vram_addr[15:8] < 8'(COLS), "R2 address", vram_addr, 0);
    end
    if (pend) begin
      mpal[pend_i] = pend_v;
      pend = 0;
    end
    rd2 = rd1; a2 = a1;
    rd1 = vram_rd; a1 = vram_addr;
  end

  task automatic write_pal(input logic [3:0] i, input logic [7:0] v);
    @(negedge clk); #1;
    pal_we = 1; pal_idx = i; pal_wdata = v;
    pend_i = i; pend_v = v; pend = 1;
    @(posedge clk); #1;
    pal_we = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!pix_valid && !vram_rd, "R1 reset outputs", {pix_valid, vram_rd}, 0);
    #1 rst_n = 1; mon_en = 1;
    @(negedge clk);
    check(vram_rd && vram_addr == {8'd0, 8'(RF)}, "R3 first read", vram_addr, {8'd0, 8'(RF)});
    repeat (60) @(negedge clk);
    for (int i = 0; i < 16; i++) write_pal(4'(i), 8'(i * 37 + 3));
    repeat (60) @(negedge clk);
    for (int v = 0; v < 9; v++) begin
      for (int i = 0; i < 16; i++) write_pal(4'(i), VEC[v][31:24]);
      repeat (4) @(negedge clk);
      #2 check({pix_r, pix_g, pix_b} == VEC[v][23:0], "R7 weight table",
               {pix_r, pix_g, pix_b}, VEC[v][23:0]);
    end
    for (int i = 15; i >= 0; i--) write_pal(4'(i), 8'(i * 91 + 17));
    repeat (60) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule